// File: doc/BRIEF.md
# Exception Entry and Exit Sequencer

This block runs the memory traffic that a small 32-bit core needs when it enters or leaves an exception handler. An arbiter outside the block picks the exception. When it hands one over, the sequencer copies a snapshot of eight context registers into a frame on a descending stack. It also reads the handler start address from a vector table. Both jobs share one word-wide memory request port. The vector read goes out first, and the stack writes follow it while the read is still in flight.

A more urgent exception can arrive while the frame is being written. In that case the arbiter pulses a redirect, and the sequencer fetches the new vector without rewriting any of the frame. On a handler return the sequencer reads the eight frame words back and gives them to the core as a restore bundle with the updated stack pointer. A return marked as a tail-chain skips both the unstacking and the restacking. It only fetches the next handler address.

Memory requests follow valid/ready rules. A request stays stable until the memory accepts it. Read responses come back in order with no back-pressure, one response per accepted read, and the block never has more than one read outstanding. Write requests get no response. The take and return inputs also use valid/ready, and the sequencer holds off each of them with its ready signal while it is working.

Top module: `exc_seq`

## Requirements
- R1: After reset, `busy`, `hdl_valid`, `ctx_valid`, `sp_upd` and `mem_req_valid` are low, and `take_ready` and `ret_ready` are high.
- R2: A take is accepted in a cycle where `take_valid` and `take_ready` are both high, and `take_ready` is high only while the block is idle. `busy` is high from the cycle after acceptance up to the cycle before `hdl_valid`, and it is low in the `hdl_valid` cycle. A `take_valid` raised while busy is ignored: it causes no extra memory traffic and does not change the handler that is delivered.
- R3: On an accepted take, `sp_out` becomes `sp_in` - 32 with a one-cycle `sp_upd` pulse in the following cycle. Exactly eight write requests are then made, in ascending address order, to `sp_out` + 4k for k = 0..7. Word k carries `ctx_in[32k +: 32]`, and the words are R0, R1, R2, R3, R12, LR, PC, PSR in that order. Writes are issued only while `busy` is high.
- R4: The first request after a take is a read of `VEC_BASE` + 4 × `take_num`. `hdl_addr` carries the response to the last valid vector read, with a one-cycle `hdl_valid` pulse once that response has arrived and all eight writes have been accepted.
- R5: A `late_valid` pulse while busy replaces the exception number with `late_num` and triggers a fresh vector read. The eight writes are not restarted, so there are exactly eight per entry. `hdl_addr` then comes from `VEC_BASE` + 4 × `late_num`. A `late_valid` pulse while idle has no effect.
- R6: A return with `ret_tail` = 0 reads the eight words at `sp_in` + 4k in ascending order and makes no writes. It then pulses `ctx_valid`, with `ctx_out[32k +: 32]` holding word k, and in the same cycle pulses `sp_upd` with `sp_out` = `sp_in` + 32.
- R7: A return with `ret_tail` = 1 makes no stack reads or writes. It makes a single read of `VEC_BASE` + 4 × `ret_num`, then delivers `hdl_addr` with `hdl_valid`. `busy` behaves as it does for a take.
- R8: A request held back by `mem_req_ready` keeps its address, data and direction until it is accepted. The block issues no read while an earlier read is still waiting for its response.
- R9: `ret_ready` is low whenever `take_valid` is high, so a take wins over a return offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_valid | input | 1 | Arbiter offers an exception to enter |
| take_ready | output | 1 | Sequencer is idle and accepts a take |
| take_num | input | NUM_W | Exception number of the offered take |
| ctx_in | input | 8*DW | Register snapshot: word k at bits 32k+31..32k (R0,R1,R2,R3,R12,LR,PC,PSR) |
| sp_in | input | AW | Current stack pointer from the core |
| late_valid | input | 1 | Redirect the pending vector fetch while busy |
| late_num | input | NUM_W | Exception number for the redirect |
| ret_valid | input | 1 | Core signals handler return |
| ret_ready | output | 1 | Sequencer accepts the return |
| ret_tail | input | 1 | Return chains directly into another handler |
| ret_num | input | NUM_W | Exception number for a tail-chain |
| busy | output | 1 | Entry or tail-chain in progress |
| hdl_valid | output | 1 | One-cycle pulse: handler address ready |
| hdl_addr | output | DW | Handler start address |
| ctx_valid | output | 1 | One-cycle pulse: restored context ready |
| ctx_out | output | 8*DW | Restored context, same word order as ctx_in |
| sp_upd | output | 1 | One-cycle pulse: new stack pointer on sp_out |
| sp_out | output | AW | Updated stack pointer |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read response present (no back-pressure) |
| mem_rsp_data | input | DW | Read response data |

## Verification
Several rules are checked on every cycle: a request held by back-pressure stays stable, no read goes out while another is outstanding, writes occur only while busy, an entry never makes more than eight writes, the take wins over a return, and busy drops in the cycle the handler address appears. Other behaviour can only be shown by the bench scenarios, which compare values with a memory model. These cover the frame contents and address order, the vector address chosen after a redirect in both early and late timing, the restored context and stack pointer after a return, the missing stack traffic on a tail-chain, and whether stray take or redirect pulses were actually ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Architectural frame: eight words, 4 bytes each.
  localparam int FRAME_WORDS = 8;
  localparam int WORD_BYTES  = 4;
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int CNT_W       = IDX_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_POP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/exc_vec_track.sv
// Tracks which vector must be fetched and whether the fetched one is still current.
module exc_vec_track #(
  parameter int          NUM_W    = 5,
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] start_num,
  input  logic             redir,
  input  logic [NUM_W-1:0] redir_num,
  input  logic             issue,
  input  logic             rsp,
  input  logic [DW-1:0]    rsp_data,
  output logic             need,
  output logic             ok,
  output logic [AW-1:0]    vaddr,
  output logic [DW-1:0]    haddr
);
  logic [NUM_W-1:0] num_q;

  assign vaddr = VEC_BASE + AW'({num_q, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      need  <= 1'b0;
      ok    <= 1'b0;
      haddr <= '0;
    end else if (start || redir) begin
      num_q <= start ? start_num : redir_num;
      need  <= 1'b1;
      ok    <= 1'b0;
    end else begin
      if (issue) need <= 1'b0;
      // A response that arrives while a refetch is pending belongs to a stale read.
      if (rsp && !need) begin
        ok    <= 1'b1;
        haddr <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/exc_req_reg.sv
// Output request register: holds a request stable until the memory accepts it.
module exc_req_reg #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          ready,
  output logic          load_ok,
  output logic          valid,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  assign load_ok = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load_ok) begin
      valid <= ld;
      if (ld) begin
        we   <= ld_we;
        addr <= ld_addr;
        data <= ld_data;
      end
    end
  end
endmodule

// File: rtl/exc_ctx_cap.sv
// Collects popped frame words into the restore bundle.
module exc_ctx_cap #(
  parameter int DW = 32,
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [N*DW-1:0] ctx
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [DW-1:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          w_q <= '0;
      else if (wr_en && wr_idx == IW'(g))  w_q <= wr_data;
    end
    assign ctx[g*DW +: DW] = w_q;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int            NUM_W    = 5,
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take_valid,
  output logic                      take_ready,
  input  logic [NUM_W-1:0]          take_num,
  input  logic [FRAME_WORDS*DW-1:0] ctx_in,
  input  logic [AW-1:0]             sp_in,
  input  logic                      late_valid,
  input  logic [NUM_W-1:0]          late_num,
  input  logic                      ret_valid,
  output logic                      ret_ready,
  input  logic                      ret_tail,
  input  logic [NUM_W-1:0]          ret_num,
  output logic                      busy,
  output logic                      hdl_valid,
  output logic [DW-1:0]             hdl_addr,
  output logic                      ctx_valid,
  output logic [FRAME_WORDS*DW-1:0] ctx_out,
  output logic                      sp_upd,
  output logic [AW-1:0]             sp_out,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [DW-1:0]             mem_rsp_data
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_WORDS);

  seq_state_e       state_q;
  logic [AW-1:0]    frame_base_q;
  logic [DW-1:0]    snap_q [FRAME_WORDS];
  logic [CNT_W-1:0] push_cnt_q, pop_iss_q, pop_rcv_q;
  logic             rd_out_q;
  logic             hdl_valid_q, ctx_valid_q, sp_upd_q;
  logic [AW-1:0]    sp_out_q;

  logic             idle, take_fire, ret_fire, start_entry, redir;
  logic [NUM_W-1:0] start_num;
  logic             vec_need, vec_ok;
  logic [AW-1:0]    vec_addr;
  logic             load_ok, ld_vec, ld_push, ld_pop, ld_any, ld_rd;
  logic             ld_we;
  logic [AW-1:0]    ld_addr;
  logic [DW-1:0]    ld_data;
  logic             done_entry, pop_rsp;

  assign idle        = (state_q == ST_IDLE);
  assign take_ready  = idle;
  assign ret_ready   = idle && !take_valid;
  assign take_fire   = take_valid && take_ready;
  assign ret_fire    = ret_valid && ret_ready;
  assign start_entry = take_fire || (ret_fire && ret_tail);
  assign start_num   = take_fire ? take_num : ret_num;
  assign redir       = late_valid && (state_q == ST_ENTRY);
  assign busy        = (state_q == ST_ENTRY);

  exc_vec_track #(.NUM_W(NUM_W), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .start(start_entry), .start_num(start_num),
    .redir(redir), .redir_num(late_num),
    .issue(ld_vec),
    .rsp(mem_rsp_valid && state_q == ST_ENTRY), .rsp_data(mem_rsp_data),
    .need(vec_need), .ok(vec_ok), .vaddr(vec_addr), .haddr(hdl_addr)
  );

  // Request selection: vector read first, pushes fill the gaps while it is in flight.
  always_comb begin
    ld_vec  = (state_q == ST_ENTRY) && load_ok && vec_need && !rd_out_q;
    ld_push = (state_q == ST_ENTRY) && load_ok && !ld_vec && (push_cnt_q < FULL);
    ld_pop  = (state_q == ST_POP) && load_ok && !rd_out_q && (pop_iss_q < FULL);
    ld_any  = ld_vec || ld_push || ld_pop;
    ld_rd   = ld_vec || ld_pop;
    ld_we   = ld_push;
    ld_data = snap_q[push_cnt_q[IDX_W-1:0]];
    if (ld_vec)       ld_addr = vec_addr;
    else if (ld_push) ld_addr = frame_base_q + AW'({push_cnt_q, 2'b00});
    else              ld_addr = frame_base_q + AW'({pop_iss_q, 2'b00});
  end

  exc_req_reg #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .ld(ld_any), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .ready(mem_req_ready), .load_ok(load_ok),
    .valid(mem_req_valid), .we(mem_we), .addr(mem_addr), .data(mem_wdata)
  );

  assign pop_rsp    = mem_rsp_valid && (state_q == ST_POP);
  assign done_entry = (state_q == ST_ENTRY) && (push_cnt_q == FULL) && vec_ok &&
                      !vec_need && !mem_req_valid && !late_valid;

  exc_ctx_cap #(.DW(DW), .N(FRAME_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pop_rsp), .wr_idx(pop_rcv_q[IDX_W-1:0]), .wr_data(mem_rsp_data),
    .ctx(ctx_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      frame_base_q <= '0;
      push_cnt_q   <= '0;
      pop_iss_q    <= '0;
      pop_rcv_q    <= '0;
      rd_out_q     <= 1'b0;
      hdl_valid_q  <= 1'b0;
      ctx_valid_q  <= 1'b0;
      sp_upd_q     <= 1'b0;
      sp_out_q     <= '0;
      for (int k = 0; k < FRAME_WORDS; k++) snap_q[k] <= '0;
    end else begin
      hdl_valid_q <= 1'b0;
      ctx_valid_q <= 1'b0;
      sp_upd_q    <= 1'b0;
      if (ld_rd)              rd_out_q <= 1'b1;
      else if (mem_rsp_valid) rd_out_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_fire) begin
            frame_base_q <= sp_in - AW'(FRAME_BYTES);
            sp_out_q     <= sp_in - AW'(FRAME_BYTES);
            sp_upd_q     <= 1'b1;
            push_cnt_q   <= '0;
            for (int k = 0; k < FRAME_WORDS; k++) snap_q[k] <= ctx_in[k*DW +: DW];
            state_q      <= ST_ENTRY;
          end else if (ret_fire && ret_tail) begin
            push_cnt_q <= FULL;
            state_q    <= ST_ENTRY;
          end else if (ret_fire) begin
            frame_base_q <= sp_in;
            pop_iss_q    <= '0;
            pop_rcv_q    <= '0;
            state_q      <= ST_POP;
          end
        end
        ST_ENTRY: begin
          if (ld_push) push_cnt_q <= push_cnt_q + 1'b1;
          if (done_entry) begin
            hdl_valid_q <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        ST_POP: begin
          if (ld_pop)  pop_iss_q <= pop_iss_q + 1'b1;
          if (pop_rsp) pop_rcv_q <= pop_rcv_q + 1'b1;
          if (pop_rcv_q == FULL) begin
            ctx_valid_q <= 1'b1;
            sp_out_q    <= frame_base_q + AW'(FRAME_BYTES);
            sp_upd_q    <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hdl_valid = hdl_valid_q;
  assign ctx_valid = ctx_valid_q;
  assign sp_upd    = sp_upd_q;
  assign sp_out    = sp_out_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_valid,
  input logic          take_ready,
  input logic          ret_ready,
  input logic          busy,
  input logic          hdl_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rsp_valid
);
  logic [1:0] rd_pend;
  logic [3:0] wr_since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= '0;
      wr_since <= '0;
    end else begin
      case ({mem_req_valid && mem_req_ready && !mem_we, mem_rsp_valid})
        2'b10:   rd_pend <= rd_pend + 1'b1;
        2'b01:   rd_pend <= rd_pend - 1'b1;
        default: rd_pend <= rd_pend;
      endcase
      if (take_valid && take_ready)                      wr_since <= '0;
      else if (mem_req_valid && mem_req_ready && mem_we) wr_since <= wr_since + 1'b1;
    end
  end

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> busy);

  a_r4_hdl_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_valid |-> (!busy && $past(busy)));

  a_r3_writes_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> busy);

  a_r5_eight_writes_max: assert property (@(posedge clk) disable iff (!rst_n)
    wr_since <= 4'd8);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r8_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_we) |-> (rd_pend == 2'd0));

  a_r9_take_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> !ret_ready);
endmodule

bind exc_seq exc_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_ready(take_ready),
  .ret_ready(ret_ready), .busy(busy), .hdl_valid(hdl_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_exc_seq.sv
module test_exc_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NW = 5;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            take_valid = 0, late_valid = 0, ret_valid = 0, ret_tail = 0;
  logic [NW-1:0]   take_num = '0, late_num = '0, ret_num = '0;
  logic [8*DW-1:0] ctx_in = '0;
  logic [AW-1:0]   sp_in = '0;
  logic            take_ready, ret_ready, busy, hdl_valid, ctx_valid, sp_upd;
  logic [DW-1:0]   hdl_addr;
  logic [8*DW-1:0] ctx_out;
  logic [AW-1:0]   sp_out;
  logic            mem_req_valid, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic            mem_req_ready = 1'b1;
  logic            mem_rsp_valid = 1'b0;
  logic [DW-1:0]   mem_rsp_data = '0;

  exc_seq i_exc_seq (
    .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_ready(take_ready),
    .take_num(take_num), .ctx_in(ctx_in), .sp_in(sp_in), .late_valid(late_valid),
    .late_num(late_num), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_tail(ret_tail), .ret_num(ret_num), .busy(busy), .hdl_valid(hdl_valid),
    .hdl_addr(hdl_addr), .ctx_valid(ctx_valid), .ctx_out(ctx_out), .sp_upd(sp_upd),
    .sp_out(sp_out), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Memory model: 256 words, vector table preset, reads answered two edges after acceptance.
  logic [DW-1:0] mem [256];
  logic          stall = 1'b0, clr = 1'b0;
  logic          p_valid = 1'b0;
  logic [7:0]    p_idx = '0;
  int            wr_cnt = 0, rd_cnt = 0;
  logic          first_is_rd = 1'b0;
  logic [AW-1:0] wr_la [16];
  logic [DW-1:0] wr_ld [16];
  logic [AW-1:0] rd_la [16];

  function automatic logic [DW-1:0] vec_of(input int n);
    return 32'h1000_0000 + 32'(n) * 32'd16;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= vec_of(i);
      p_valid <= 1'b0;
      mem_rsp_valid <= 1'b0;
    end else begin
      mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
      mem_rsp_valid <= p_valid;
      mem_rsp_data  <= mem[p_idx];
      p_valid <= mem_req_valid && mem_req_ready && !mem_we;
      p_idx   <= mem_addr[9:2];
      if (mem_req_valid && mem_req_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (wr_cnt + rd_cnt == 0) first_is_rd <= !mem_we;
      if (mem_we) begin
        wr_la[wr_cnt[3:0]] <= mem_addr;
        wr_ld[wr_cnt[3:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_la[rd_cnt[3:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8*DW-1:0] mk_ctx(input int seed);
    logic [8*DW-1:0] c;
    for (int k = 0; k < 8; k++) c[k*DW +: DW] = 32'hA000_0000 | (32'(seed) << 8) | 32'(k);
    return c;
  endfunction

  task automatic clear_log();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic wait_hdl(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (hdl_valid) begin
        got = 1;
        break;
      end
    end
  endtask

  // Shared entry driver; late_at < 0 means no redirect, ign drives stray takes while busy.
  task automatic run_entry(input int num, input logic [AW-1:0] sp, input int seed,
                           input int late_at, input int lnum, input bit ign,
                           output bit got, output int busy_seen);
    clear_log();
    take_valid = 1; take_num = NW'(num); sp_in = sp; ctx_in = mk_ctx(seed);
    @(negedge clk);
    take_valid = 0;
    chk(sp_upd == 1'b1 && sp_out == sp - 32, "R3 sp_out on entry", sp_out, sp - 32);
    chk(busy == 1'b1, "R2 busy after take", busy, 1);
    busy_seen = 1;
    got = 0;
    for (int c = 0; c < 400; c++) begin
      if (c == late_at) begin late_valid = 1; late_num = NW'(lnum); end
      if (ign && c < 3) begin take_valid = 1; take_num = NW'(num + 7); end
      @(negedge clk);
      if (ign && c < 3) chk(take_ready == 1'b0, "R2 take_ready low while busy", take_ready, 0);
      late_valid = 0;
      take_valid = 0;
      if (hdl_valid) begin
        got = 1;
        break;
      end
      if (busy) busy_seen++;
    end
    chk(got && busy == 1'b0, "R2 busy low with hdl_valid", busy, 0);
  endtask

  task automatic check_frame(input logic [AW-1:0] sp, input int seed, input string tag);
    logic [8*DW-1:0] c;
    c = mk_ctx(seed);
    chk(wr_cnt == 8, {tag, " eight writes"}, wr_cnt, 8);
    for (int k = 0; k < 8; k++) begin
      chk(wr_la[k] == sp - 32 + 32'(4 * k) && wr_ld[k] == c[k*DW +: DW],
          {tag, " frame word"}, {wr_la[k], wr_ld[k]}, {sp - 32 + 32'(4 * k), c[k*DW +: DW]});
    end
  endtask

  task automatic t_reset();
    chk(busy == 0 && hdl_valid == 0 && ctx_valid == 0 && sp_upd == 0, "R1 outputs idle",
        {busy, hdl_valid, ctx_valid, sp_upd}, 0);
    chk(take_ready == 1 && ret_ready == 1, "R1 ready high", {take_ready, ret_ready}, 2'b11);
    chk(mem_req_valid == 0, "R1 no request", mem_req_valid, 0);
  endtask

  task automatic t_entry_basic(input bit st);
    bit got; int bs;
    stall = st;
    run_entry(5, 32'h300, 1, -1, 0, 0, got, bs);
    chk(hdl_addr == vec_of(5), "R4 handler address", hdl_addr, vec_of(5));
    chk(first_is_rd && rd_cnt == 1 && rd_la[0] == 32'(5 * 4), "R4 vector read first",
        {first_is_rd, rd_la[0]}, {1'b1, 32'(20)});
    check_frame(32'h300, 1, st ? "R8 R3 stalled" : "R3");
    stall = 0;
  endtask

  task automatic t_return(input bit st);
    bit got;
    stall = st;
    clear_log();
    ret_valid = 1; ret_tail = 0; sp_in = 32'h2E0;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ret_valid = 0;
      if (ctx_valid) begin got = 1; break; end
    end
    chk(got && ctx_out == mk_ctx(1), "R6 restored context", ctx_out, mk_ctx(1));
    chk(sp_upd && sp_out == 32'h300, "R6 sp_out after pop", sp_out, 32'h300);
    chk(rd_cnt == 8 && wr_cnt == 0, "R6 eight reads no writes", {rd_cnt, wr_cnt}, {32'd8, 32'd0});
    for (int k = 0; k < 8; k++)
      chk(rd_la[k] == 32'h2E0 + 32'(4 * k), "R6 pop address order", rd_la[k], 32'h2E0 + 32'(4 * k));
    stall = 0;
  endtask

  task automatic t_late(input int at, input bit st);
    bit got; int bs;
    stall = st;
    run_entry(3, 32'h300, 2, at, 9, 0, got, bs);
    chk(hdl_addr == vec_of(9), "R5 redirected handler", hdl_addr, vec_of(9));
    chk(wr_cnt == 8, "R5 stacking not restarted", wr_cnt, 8);
    stall = 0;
  endtask

  task automatic t_late_idle();
    bit got; int bs;
    clear_log();
    late_valid = 1; late_num = 5'd12;
    @(negedge clk);
    late_valid = 0;
    @(negedge clk);
    chk(mem_req_valid == 0 && busy == 0, "R5 idle redirect no traffic", {mem_req_valid, busy}, 0);
    run_entry(4, 32'h300, 3, -1, 0, 0, got, bs);
    chk(hdl_addr == vec_of(4), "R5 idle redirect ignored", hdl_addr, vec_of(4));
  endtask

  task automatic t_ignore_take();
    bit got; int bs;
    run_entry(6, 32'h300, 4, -1, 0, 1, got, bs);
    chk(hdl_addr == vec_of(6), "R2 stray take ignored", hdl_addr, vec_of(6));
    chk(wr_cnt == 8 && rd_cnt == 1, "R2 no extra traffic", {wr_cnt, rd_cnt}, {32'd8, 32'd1});
  endtask

  task automatic t_tail();
    bit got;
    clear_log();
    ret_valid = 1; ret_tail = 1; ret_num = 5'd17;
    @(negedge clk);
    ret_valid = 0; ret_tail = 0;
    chk(busy == 1, "R7 busy on tail-chain", busy, 1);
    wait_hdl(got);
    chk(got && hdl_addr == vec_of(17), "R7 tail handler", hdl_addr, vec_of(17));
    chk(wr_cnt == 0 && rd_cnt == 1 && rd_la[0] == 32'(17 * 4), "R7 vector only",
        {wr_cnt, rd_cnt, rd_la[0]}, {32'd0, 32'd1, 32'(68)});
  endtask

  task automatic t_priority();
    bit got; int bs;
    @(negedge clk);
    ret_valid = 1; ret_tail = 0; take_valid = 1;
    #1;
    chk(ret_ready == 0 && take_ready == 1, "R9 take wins", {ret_ready, take_ready}, 2'b01);
    take_valid = 0;
    ret_valid = 0;
    run_entry(2, 32'h300, 5, -1, 0, 0, got, bs);
    chk(hdl_addr == vec_of(2) && rd_cnt == 1, "R9 only take served", hdl_addr, vec_of(2));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_entry_basic(0);
    t_return(0);
    t_entry_basic(1);
    t_return(1);
    t_late(1, 0);
    t_late(8, 1);
    t_late_idle();
    t_ignore_take();
    t_tail();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule